// File: doc/BRIEF.md
# Wake-up Event Flag Capture

The block turns three raw wake-up event sources into sticky pending flags that software can read. The sources are a programmable wake source, a software-triggered event and a real-time-counter compare channel. Each event input is synchronized to the block clock and edge-detected, so every distinct event sets its flag once, however long the input stays high.

Software clears flags through a separate clear register that uses a level handshake. A clear bit is written to 1 and held there until the matching flag reads 0, and then written back to 0. The programmable flag can be cleared only when the selected source is itself clearable, which an input qualifier reports. When the programmable source is the compare channel, the compare-channel clear also clears the programmable flag. An event that arrives while its clear is held is not lost. It sets the flag once the clear is released. A combined wake request is raised when any pending flag belongs to a source that is enabled for wake-up.

Top module: `wake_flag_capture`

## Requirements
- R1: After reset, the flag vector, the clear register readback and the wake request are all 0.
- R2: Flag bit 0 belongs to the programmable source, bit 1 to the software event and bit 2 to the compare channel. A rising edge on a source's event input sets its flag on the third clock edge after the input is first sampled high (two synchronizer stages plus the flag register).
- R3: An event input held high for many cycles sets its flag only once. After that flag is cleared, it stays 0 until the input falls and rises again.
- R4: A set flag stays set for as long as no effective clear applies to it.
- R5: A write to the clear register loads the written 3-bit value, with bit i clearing flag i, on the write edge and returns it on clr_o. Without a write, the register keeps its value.
- R6: While clear bit 1 or bit 2 is 1, the matching flag is 0 from the next clock edge on and stays 0 as long as the bit is held.
- R7: Clear bit 0 clears the programmable flag only while prog_clearable_i is 1. Otherwise it has no effect on that flag.
- R8: While prog_is_rtc_i is 1, clear bit 2 also clears the programmable flag, whatever the value of prog_clearable_i.
- R9: An event that arrives while its flag's clear is in effect leaves the flag at 0. The flag sets on the clock edge after the clear stops applying.
- R10: wake_req_o is 1 exactly when some flag i is 1 and wake_en_i[i] is 1.
- R11: The compare-channel flag sets on every compare event, including when wake_en_i[2] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_prog_i | input | 1 | Raw event from the programmable wake source |
| ev_sw_i | input | 1 | Raw software-triggered event |
| ev_rtc_i | input | 1 | Raw compare-channel event |
| prog_clearable_i | input | 1 | Programmable source can be cleared (I/O event with input enabled) |
| prog_is_rtc_i | input | 1 | Programmable source is the compare channel |
| wake_en_i | input | 3 | Per-flag wake-source enable |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 3 | Clear register write data |
| clr_o | output | 3 | Clear register readback |
| flags_o | output | 3 | Pending event flags |
| wake_req_o | output | 1 | Combined wake request |

## Verification
The bench reads the flags at the ports. A corrupted flag register shows up as a wrong bit on flags_o and on wake_req_o in the same cycle. A lost or duplicated edge, or a wrong synchronizer depth, moves the set cycle away from the third edge or makes a flag set again after it has been cleared while the input is still high. If the deferred-event state is wrong, a flag either sets while its clear is held or fails to set one edge after the clear is released. The sweeps cover every combination of the two clear qualifiers and every pair of flag pattern and wake-enable value.

// File: rtl/wuf_pkg.sv
package wuf_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned SRC_PROG = 0;
  localparam int unsigned SRC_SW   = 1;
  localparam int unsigned SRC_RTC  = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/wuf_sync_edge.sv
module wuf_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // a held input yields one strobe only
  p_single_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wuf_clr_reg.sv
module wuf_clr_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] clr_o
);
  logic [W-1:0] clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   clr_q <= '0;
    else if (we_i) clr_q <= wdata_i;
  end

  assign clr_o = clr_q;

  p_clr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> clr_o == $past(wdata_i));
  p_clr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(clr_o));
endmodule

// File: rtl/wuf_flag_cell.sv
module wuf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic defer_q;

  // an event seen under clear is held back until the clear drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      defer_q <= 1'b0;
    end else if (clr_i) begin
      flag_q  <= 1'b0;
      defer_q <= defer_q | set_i;
    end else begin
      flag_q  <= flag_q | set_i | defer_q;
      defer_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_defer_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (defer_q && !clr_i) |=> flag_o);
  p_set_has_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i || defer_q));
endmodule

// File: rtl/wake_flag_capture.sv
module wake_flag_capture
  import wuf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ev_prog_i,
  input  logic         ev_sw_i,
  input  logic         ev_rtc_i,
  input  logic         prog_clearable_i,
  input  logic         prog_is_rtc_i,
  input  logic [2:0]   wake_en_i,
  input  logic         clr_we_i,
  input  logic [2:0]   clr_wdata_i,
  output logic [2:0]   clr_o,
  output logic [2:0]   flags_o,
  output logic         wake_req_o
);
  src_vec_t ev_raw;
  src_vec_t ev_rise;
  src_vec_t clr_q;
  src_vec_t clr_eff;
  src_vec_t flag_q;

  assign ev_raw[SRC_PROG] = ev_prog_i;
  assign ev_raw[SRC_SW]   = ev_sw_i;
  assign ev_raw[SRC_RTC]  = ev_rtc_i;

  wuf_clr_reg #(.W(NUM_SRC)) u_clr_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (clr_we_i),
    .wdata_i (clr_wdata_i),
    .clr_o   (clr_q)
  );

  // programmable source: own clear needs a clearable source; shares rtc clear
  always_comb begin
    clr_eff           = clr_q;
    clr_eff[SRC_PROG] = (clr_q[SRC_PROG] & prog_clearable_i)
                      | (clr_q[SRC_RTC] & prog_is_rtc_i);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    wuf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ev_raw[i]),
      .rise_o  (ev_rise[i])
    );
    wuf_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_rise[i]),
      .clr_i  (clr_eff[i]),
      .flag_o (flag_q[i])
    );
  end

  assign clr_o      = clr_q;
  assign flags_o    = flag_q;
  assign wake_req_o = |(flag_q & wake_en_i);

  p_rtc_clears_prog_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o[SRC_RTC] && prog_is_rtc_i) |=> !flags_o[SRC_PROG]);
  p_prog_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[SRC_PROG] && !prog_clearable_i
     && !(prog_is_rtc_i && clr_o[SRC_RTC])) |=> flags_o[SRC_PROG]);
endmodule

// File: tb/wake_flag_capture_tb.sv
`timescale 1ns/1ps
module wake_flag_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_prog = 0, ev_sw = 0, ev_rtc = 0;
  logic       prog_clr_ok = 1'b1, prog_rtc = 1'b0;
  logic [2:0] wake_en = 3'b000;
  logic       clr_we = 1'b0;
  logic [2:0] clr_wd = 3'b000;
  logic [2:0] clr_rd, flags;
  logic       wake;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  wake_flag_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_prog_i(ev_prog), .ev_sw_i(ev_sw), .ev_rtc_i(ev_rtc),
    .prog_clearable_i(prog_clr_ok), .prog_is_rtc_i(prog_rtc),
    .wake_en_i(wake_en), .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .clr_o(clr_rd), .flags_o(flags), .wake_req_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ev(input logic [2:0] v);
    ev_prog = v[0]; ev_sw = v[1]; ev_rtc = v[2];
  endtask

  task automatic pulse(input logic [2:0] v);
    set_ev(v); tick(1); set_ev(3'b000); tick(3);
  endtask

  task automatic write_clr(input logic [2:0] v);
    clr_we = 1'b1; clr_wd = v; tick(1); clr_we = 1'b0;
  endtask

  task automatic clear_all();
    prog_clr_ok = 1'b1; write_clr(3'b111); tick(1); write_clr(3'b000); tick(1);
  endtask

  initial begin
    tick(3);
    check("R1 flags", flags, 0);
    check("R1 clr", clr_rd, 0);
    check("R1 wake", wake, 0);
    rst_n = 1'b1;
    tick(2);

    // R2: bit mapping and set latency
    for (int i = 0; i < 3; i++) begin
      set_ev(3'b001 << i); tick(2);
      check("R2 not yet", flags, 0);
      tick(1);
      check("R2 set", flags, 3'b001 << i);
      set_ev(3'b000);
      write_clr(3'b001 << i); tick(1);
      check("R6 cleared", flags, 0);
      write_clr(3'b000); tick(1);
    end

    // R4 sticky
    pulse(3'b010); tick(20);
    check("R4 sticky", flags, 3'b010);
    write_clr(3'b010); tick(5);
    check("R6 held clear", flags, 0);
    write_clr(3'b000); tick(1);

    // R3 long input sets once
    ev_sw = 1'b1; tick(3);
    check("R3 first set", flags, 3'b010);
    write_clr(3'b010); tick(1);
    write_clr(3'b000); tick(6);
    check("R3 no reset while high", flags, 0);
    ev_sw = 1'b0; tick(4);
    check("R3 after fall", flags, 0);

    // R5 clear register
    write_clr(3'b101);
    check("R5 load", clr_rd, 3'b101);
    clr_wd = 3'b010; tick(3);
    check("R5 hold", clr_rd, 3'b101);
    write_clr(3'b000);
    check("R5 load zero", clr_rd, 0);
    tick(1);

    // R7/R8 sweep over qualifiers
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 2; r++) begin
        prog_clr_ok = c[0]; prog_rtc = r[0];
        pulse(3'b101);
        check("R2 both set", flags, 3'b101);
        write_clr(3'b001); tick(3);
        check("R7 prog clear", flags, c ? 3'b100 : 3'b101);
        write_clr(3'b000); tick(1);
        write_clr(3'b100); tick(1);
        check("R8 rtc clear", flags, (c || r) ? 3'b000 : 3'b001);
        write_clr(3'b000); tick(1);
        clear_all();
        check("R8 restore", flags, 0);
      end
    end
    prog_rtc = 1'b0;

    // R9 deferred event
    write_clr(3'b010); tick(1);
    pulse(3'b010);
    check("R9 blocked", flags, 0);
    write_clr(3'b000);
    check("R9 still blocked", flags, 0);
    tick(1);
    check("R9 released", flags, 3'b010);
    clear_all();

    // R11 compare flag regardless of wake enable
    wake_en = 3'b000;
    pulse(3'b100);
    check("R11 rtc set", flags, 3'b100);
    check("R11 no wake", wake, 0);
    clear_all();

    // R10 sweep
    for (int f = 0; f < 8; f++) begin
      pulse(f[2:0]);
      check("R10 pattern", flags, f);
      for (int e = 0; e < 8; e++) begin
        wake_en = e[2:0]; #1;
        check("R10 wake", wake, |(f[2:0] & e[2:0]));
      end
      wake_en = 3'b000;
      clear_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule